// File: doc/BRIEF.md
# Run-of-Ones Detector

This block watches a serial bit stream, one bit per clock on a single data line, and flags every cycle in which a run of three or more consecutive 1 bits is in progress. The same detection is produced two ways, side by side. One flag comes from a three-state machine whose output combines the registered state with the live input bit, so it rises in the same cycle as the third 1. The other comes from a four-state machine whose output is decoded from the state register alone, so it rises one clock later.

Runs overlap. Once three 1s have arrived, every further 1 raises the flags again, and this continues until a 0 ends the run. A 0 always sends both machines back to their idle state.

A single parameter picks the state-code assignment used inside both machines. Either choice gives the same port behaviour. A synchronous active-high reset puts both machines in idle.

Top module: `run_det_top`

## Requirements
- R1: While `rst` is high at a clock edge, both machines enter idle. While `rst` is high, `hit_now` is 0 even when `din` is 1. In the cycle after reset is released, both outputs are 0.
- R2: A 0 on `din` makes `hit_now` 0 in that cycle and sends both machines to idle, so `hit_reg` is 0 in the following cycle.
- R3: `hit_now` is 1 in any cycle where `din` is 1 and at least two 1s were accepted in a row just before it.
- R4: `hit_now` is 0 in any cycle where fewer than two consecutive 1s precede the current bit.
- R5: `hit_reg` is 1 exactly in those cycles that follow the acceptance of at least three consecutive 1s.
- R6: Outside reset, `hit_reg` in each cycle equals the value `hit_now` had in the previous cycle.
- R7: With `ALT_ENC`=0, the three-state machine uses codes idle=00, one=01, run=10, and the four-state machine uses idle=00, one=01, run-first=10, run-more=11. With `ALT_ENC`=1, the three-state machine uses idle=00, one=01, run=11, and the four-state machine uses idle=00, one=01, run-first=11, run-more=10. The outputs are identical under both settings. An unused code decodes as idle.
- R8: Detection overlaps. During a run of N ≥ 3 ones, `hit_now` is 1 on the 3rd through Nth bits of the run, and `hit_reg` is 1 in each cycle after those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| din | input | 1 | Serial data bit |
| hit_now | output | 1 | Input-dependent detection flag |
| hit_reg | output | 1 | State-only detection flag, one cycle later |

## Verification
The bench builds two copies of the block at the same time, one with `ALT_ENC`=0 and one with `ALT_ENC`=1, and feeds both the same stimulus. Each copy is compared against a saturating count of consecutive 1s, and the two copies are also compared with each other. The stimulus runs every 8-bit pattern starting from reset. That covers every run length from zero to eight, runs that start or end at either edge of the pattern, and every transition of both machines under both code assignments.

// File: rtl/run_det_pkg.sv
package run_det_pkg;

    localparam int STW = 2;
    typedef logic [STW-1:0] code_t;

    // Abstract states of the three-state machine
    typedef enum logic [1:0] {
        MY_IDLE = 2'd0,
        MY_ONE  = 2'd1,
        MY_RUN  = 2'd2
    } my_state_e;

    // Abstract states of the four-state machine
    typedef enum logic [1:0] {
        MO_IDLE = 2'd0,
        MO_ONE  = 2'd1,
        MO_RUN0 = 2'd2,
        MO_RUN1 = 2'd3
    } mo_state_e;

    function automatic code_t my_encode(my_state_e s, logic alt);
        case (s)
            MY_IDLE: my_encode = 2'b00;
            MY_ONE:  my_encode = 2'b01;
            MY_RUN:  my_encode = alt ? 2'b11 : 2'b10;
            default: my_encode = 2'b00;
        endcase
    endfunction

    function automatic my_state_e my_decode(code_t c, logic alt);
        if (c == 2'b01)
            my_decode = MY_ONE;
        else if (c == (alt ? 2'b11 : 2'b10))
            my_decode = MY_RUN;
        else
            my_decode = MY_IDLE;
    endfunction

    function automatic code_t mo_encode(mo_state_e s, logic alt);
        case (s)
            MO_IDLE: mo_encode = 2'b00;
            MO_ONE:  mo_encode = 2'b01;
            MO_RUN0: mo_encode = alt ? 2'b11 : 2'b10;
            MO_RUN1: mo_encode = alt ? 2'b10 : 2'b11;
            default: mo_encode = 2'b00;
        endcase
    endfunction

    function automatic mo_state_e mo_decode(code_t c, logic alt);
        case (c)
            2'b00:   mo_decode = MO_IDLE;
            2'b01:   mo_decode = MO_ONE;
            2'b10:   mo_decode = alt ? MO_RUN1 : MO_RUN0;
            default: mo_decode = alt ? MO_RUN0 : MO_RUN1;
        endcase
    endfunction

endpackage

// File: rtl/run_det_mealy.sv
module run_det_mealy
    import run_det_pkg::*;
#(
    parameter bit ALT_ENC = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    code_t     st_q;
    code_t     st_d;
    my_state_e cur;
    my_state_e nxt;

    always_comb begin
        cur = my_decode(st_q, ALT_ENC);
        if (!din)
            nxt = MY_IDLE;
        else if (cur == MY_IDLE)
            nxt = MY_ONE;
        else
            nxt = MY_RUN;
        st_d = my_encode(nxt, ALT_ENC);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= my_encode(MY_IDLE, ALT_ENC);
        else
            st_q <= st_d;
    end

    assign hit = (cur == MY_RUN) && din && !rst;

    // R1
    always_comb begin
        if (rst) rst_quiet_chk: assert (!hit);
    end

    // R3
    hit_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> din);

    // R2
    zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !din |=> !hit);

    generate
        if (ALT_ENC) begin : g_alt
            // R7
            legal_code_chk: assert property (@(posedge clk) disable iff (rst)
                st_q != 2'b10);
        end
    endgenerate

endmodule

// File: rtl/run_det_moore.sv
module run_det_moore
    import run_det_pkg::*;
#(
    parameter bit ALT_ENC = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    code_t     st_q;
    code_t     st_d;
    mo_state_e cur;
    mo_state_e nxt;

    always_comb begin
        cur = mo_decode(st_q, ALT_ENC);
        if (!din)
            nxt = MO_IDLE;
        else begin
            case (cur)
                MO_IDLE: nxt = MO_ONE;
                MO_ONE:  nxt = MO_RUN0;
                default: nxt = MO_RUN1;
            endcase
        end
        st_d = mo_encode(nxt, ALT_ENC);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= mo_encode(MO_IDLE, ALT_ENC);
        else
            st_q <= st_d;
    end

    assign hit = (cur == MO_RUN1);

    // R8
    run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && din) |=> hit);

    // R2
    zero_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !din |=> !hit);

endmodule

// File: rtl/run_det_top.sv
module run_det_top
    import run_det_pkg::*;
#(
    parameter bit ALT_ENC = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit_now,
    output logic hit_reg
);

    run_det_mealy #(.ALT_ENC(ALT_ENC)) u_mealy (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit_now)
    );

    run_det_moore #(.ALT_ENC(ALT_ENC)) u_moore (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit_reg)
    );

    logic seen_rst;
    logic armed;
    always_ff @(posedge clk) begin
        seen_rst <= seen_rst | rst;
        armed    <= seen_rst & !rst;
    end

    // R6
    lag_one_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (hit_reg == $past(hit_now)));

endmodule

// File: tb/run_det_top_test.sv
module run_det_top_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic din;
    logic now_b, reg_b, now_a, reg_a;
    int   nvec = 0;
    int   nbad = 0;

    run_det_top #(.ALT_ENC(1'b0)) uut (
        .clk(clk), .rst(rst), .din(din), .hit_now(now_b), .hit_reg(reg_b));

    run_det_top #(.ALT_ENC(1'b1)) uut_alt (
        .clk(clk), .rst(rst), .din(din), .hit_now(now_a), .hit_reg(reg_a));

    task automatic chk(input string req, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        nvec++;
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int run;
        logic exp_now;
        rst = 1'b1;
        din = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset held, input high
        chk("R1 now bin", now_b, 1'b0);
        chk("R1 now alt", now_a, 1'b0);
        chk("R1 reg bin", reg_b, 1'b0);
        chk("R1 reg alt", reg_a, 1'b0);
        for (int pat = 0; pat < 256; pat++) begin
            rst = 1'b1;
            din = 1'b1;
            #1;
            chk("R1 gated", now_b | now_a, 1'b0);
            @(posedge clk);
            @(negedge clk);
            rst = 1'b0;
            run = 0;
            for (int i = 0; i < 8; i++) begin
                din = pat[i];
                #1;
                exp_now = din && (run >= 2);
                if (!din) begin
                    chk("R2 now bin", now_b, 1'b0);
                    chk("R2 now alt", now_a, 1'b0);
                end else if (run >= 2) begin
                    chk("R3 now bin", now_b, 1'b1);
                    chk("R8 now alt", now_a, 1'b1);
                end else begin
                    chk("R4 now bin", now_b, 1'b0);
                    chk("R4 now alt", now_a, 1'b0);
                end
                chk("R5 reg bin", reg_b, run >= 3);
                chk("R6 reg alt", reg_a, run >= 3);
                chk("R7 now match", now_a, now_b);
                chk("R7 reg match", reg_a, reg_b);
                @(posedge clk);
                @(negedge clk);
                run = din ? ((run < 3) ? run + 1 : 3) : 0;
                if (!din) chk("R2 reg idle", reg_b | reg_a, 1'b0);
                if (exp_now) chk("R6 lag", reg_b & reg_a, 1'b1);
            end
            chk("R5 tail bin", reg_b, run >= 3);
            chk("R8 tail alt", reg_a, run >= 3);
        end
        finish_run();
    end

endmodule